// File: doc/BRIEF.md
# Conversion Mode Sequencer with Ready Flag

This block decides when a conversion result is produced and when it is flagged as ready to read. A 3-bit mode field selects continuous, single-shot, idle, power-down or one of four calibration runs. A 4-bit rate field selects the output update rate. The block keeps the data word and an 8-bit status byte. It also drives the external power-switch enable and pulses a write strobe for the offset or full-scale coefficient store when a calibration ends. It does none of the filter arithmetic. The result word comes in on an abstract port, and the rate itself comes from a period tick generated outside the block.

The ready flag is a timed flag, not a one-cycle valid pulse. It becomes active when a result lands in the data register. It becomes inactive when the data is read or when the mode register is written. In continuous mode it also becomes inactive on the advance warning of the next update if the pending word has not been read. After reset, a mode write or a restart, the first result arrives only after two conversion periods. Later results in continuous mode arrive every period.

Top module: `mode_conv_seq`

## Requirements
- R1: `mode_now` reports the current mode, using this encoding: 000 continuous, 001 single, 010 idle, 011 power-down, 100 internal zero-scale calibration, 101 internal full-scale calibration, 110 system offset calibration, 111 system full-scale calibration. Reset selects 000. A mode write takes effect at the next clock.
- R2: After reset, after a mode write or after a restart strobe, the first conversion completes on the second live period tick. In continuous mode every later tick completes a conversion. A completed conversion stores the result in `data_out` and makes ready active.
- R3: In single mode, one conversion completes on the second tick and the mode then becomes 011. Ready stays active through later update warnings until the data is read or a new mode is written.
- R4: A calibration mode (1xx) makes ready inactive when it is written. On completion it pulses exactly one of two strobes for one cycle, makes ready active and switches the mode to 010. The strobe is `cal_ofs_we` for 100 and 110, and `cal_fs_we` for 101 and 111. Completion takes 2 ticks, except for mode 101 with gain code other than 000, which takes 4 ticks.
- R5: A write of mode 101 while the gain code is 111 is rejected. The mode becomes 010 and no strobe ever follows.
- R6: Ready is status bit 7, where 0 means ready and 1 means not ready. It becomes 1 on a data read, on any mode write, and in continuous mode on `period_warn` while an unread result is pending.
- R7: When a data read and a conversion completion fall in the same cycle, the completion wins. Ready ends that cycle active and holds the new result.
- R8: Status bit 6 (error) is written at each conversion completion. It is 1 when the stored word was clamped: over-range stores all ones and under-range stores all zeros. A mode write or a restart clears it.
- R9: While reference detection is enabled and the reference is missing, status bit 5 reads 1 from the next cycle. Results completed in that state are all ones, with the error bit set.
- R10: `rate_centihz` gives the selected update rate in hundredths of a hertz. Codes 0001 to 1111 give 50000, 25000, 12500, 6250, 5000, 4160, 3330, 1960, 1660, 1660, 1250, 1000, 833, 625 and 417. Code 0000 gives 0, and while it is selected period ticks are ignored.
- R11: `psw_on` follows the switch control bit written with the mode, but it is forced to 0 while the mode is 011.
- R12: Status bits 2:0 show the channel input as registered one cycle earlier. Bit 4 reads 0. Bit 3 reads 1 when the data width exceeds 16. The reset value of the status byte is 0x88 at width 24.
- R13: In modes 010 and 011 period ticks produce no result and no strobe, and `data_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode code being written |
| psw_wdata | input | 1 | Power-switch control bit being written |
| rate_wdata | input | 4 | Rate code being written |
| restart | input | 1 | Configuration write: restarts the settle count and clears error |
| cfg_gain | input | 3 | Gain code from configuration |
| cfg_chan | input | 3 | Selected channel from configuration |
| ref_det_en | input | 1 | Reference detection enable |
| period_tick | input | 1 | One conversion period elapsed |
| period_warn | input | 1 | Advance warning of the next period tick |
| raw_result | input | DW | Result word from the modulator port |
| over_range | input | 1 | Result above full scale |
| under_range | input | 1 | Result below zero scale |
| ref_missing | input | 1 | Reference voltage absent |
| data_rd | input | 1 | Data register read strobe |
| data_out | output | DW | Data register |
| status | output | 8 | Status byte |
| mode_now | output | 3 | Current mode |
| rate_centihz | output | 16 | Decoded update rate |
| psw_on | output | 1 | Power-switch close |
| cal_ofs_we | output | 1 | Offset coefficient write strobe |
| cal_fs_we | output | 1 | Full-scale coefficient write strobe |

## Verification
The sharpest overlap is a data read that arrives in the very cycle a conversion completes. The bench provokes it by raising `data_rd` together with `period_tick` while a result is pending. It judges the outcome on ready being active afterwards and on `data_out` holding the freshly captured word. A second overlap is a mode write or restart that collides with a tick; the settle reload must suppress the completion. The per-clock reference model catches either ordering mistake on the following cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    M_CONT   = 3'd0,
    M_SINGLE = 3'd1,
    M_IDLE   = 3'd2,
    M_PDOWN  = 3'd3,
    M_CAL_IZ = 3'd4,
    M_CAL_IF = 3'd5,
    M_CAL_SZ = 3'd6,
    M_CAL_SF = 3'd7
  } mode_e;

  localparam logic [3:0] RATE_RESET = 4'b1010;

  // update rate in hundredths of a hertz, 0 for the unusable code
  function automatic logic [15:0] rate_centihz_of(input logic [3:0] code);
    case (code)
      4'd1:    return 16'd50000;
      4'd2:    return 16'd25000;
      4'd3:    return 16'd12500;
      4'd4:    return 16'd6250;
      4'd5:    return 16'd5000;
      4'd6:    return 16'd4160;
      4'd7:    return 16'd3330;
      4'd8:    return 16'd1960;
      4'd9:    return 16'd1660;
      4'd10:   return 16'd1660;
      4'd11:   return 16'd1250;
      4'd12:   return 16'd1000;
      4'd13:   return 16'd833;
      4'd14:   return 16'd625;
      4'd15:   return 16'd417;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic mode_converts(input mode_e m);
    return !(m == M_IDLE || m == M_PDOWN);
  endfunction

  function automatic logic mode_is_cal(input mode_e m);
    return m inside {M_CAL_IZ, M_CAL_IF, M_CAL_SZ, M_CAL_SF};
  endfunction

  function automatic logic mode_is_fs_cal(input mode_e m);
    return m == M_CAL_IF || m == M_CAL_SF;
  endfunction

  function automatic logic cal_rejected(input mode_e m, input logic [2:0] gain);
    return m == M_CAL_IF && gain == 3'b111;
  endfunction

  // number of period ticks before a run completes
  function automatic int periods_needed(input mode_e m, input logic [2:0] gain,
                                        input int settle, input int cal_long);
    return (m == M_CAL_IF && gain != 3'b000) ? cal_long : settle;
  endfunction

endpackage

// File: rtl/mcs_rate_dec.sv
module mcs_rate_dec
  import mcs_pkg::*;
(
  input  logic [3:0]  code,
  output logic [15:0] centihz,
  output logic        valid
);
  assign centihz = rate_centihz_of(code);
  assign valid   = (code != 4'd0);
endmodule

// File: rtl/mcs_settle_cnt.sv
module mcs_settle_cnt #(
  parameter int CW     = 3,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          hold,
  input  logic          step,
  output logic          expire
);
  localparam logic [CW-1:0] RST_VAL = CW'(SETTLE);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q;

  assign expire = step & ~load & ~hold & (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= RST_VAL;
    else if (load)                  cnt_q <= load_val;
    else if (hold)                  cnt_q <= RST_VAL;
    else if (step && cnt_q > ONE)   cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/mcs_result_cap.sv
module mcs_result_cap #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] raw,
  input  logic          over,
  input  logic          under,
  input  logic          force_ones,
  output logic [DW-1:0] data_q,
  output logic          clamped
);
  logic [DW-1:0] shaped;

  always_comb begin
    clamped = 1'b1;
    if (force_ones || over) shaped = '1;
    else if (under)         shaped = '0;
    else begin
      shaped  = raw;
      clamped = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= shaped;
  end
endmodule

// File: rtl/mode_conv_seq.sv
module mode_conv_seq
  import mcs_pkg::*;
#(
  parameter int DW       = 24,
  parameter int SETTLE   = 2,
  parameter int CAL_LONG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [2:0]    mode_wdata,
  input  logic          psw_wdata,
  input  logic [3:0]    rate_wdata,
  input  logic          restart,
  input  logic [2:0]    cfg_gain,
  input  logic [2:0]    cfg_chan,
  input  logic          ref_det_en,
  input  logic          period_tick,
  input  logic          period_warn,
  input  logic [DW-1:0] raw_result,
  input  logic          over_range,
  input  logic          under_range,
  input  logic          ref_missing,
  input  logic          data_rd,
  output logic [DW-1:0] data_out,
  output logic [7:0]    status,
  output logic [2:0]    mode_now,
  output logic [15:0]   rate_centihz,
  output logic          psw_on,
  output logic          cal_ofs_we,
  output logic          cal_fs_we
);
  localparam int   CW   = $clog2(CAL_LONG + 1);
  localparam logic WIDE = (DW > 16);

  mode_e      mode_q;
  logic       psw_q;
  logic [3:0] rate_q;
  logic       nrdy_q, err_q, noref_q;
  logic [2:0] chan_q;
  logic       ofs_we_q, fs_we_q;

  // decoded write
  mode_e wr_mode_raw, wr_mode;
  logic  wr_reject;
  assign wr_mode_raw = mode_e'(mode_wdata);
  assign wr_reject   = cal_rejected(wr_mode_raw, cfg_gain);
  assign wr_mode     = wr_reject ? M_IDLE : wr_mode_raw;

  // rate decode
  logic        rate_ok;
  logic [15:0] rate_val;
  mcs_rate_dec u_rate (.code(rate_q), .centihz(rate_val), .valid(rate_ok));

  // named events
  logic ev_mode_wr, ev_restart, ev_hold, ev_live_tick, ev_done, ev_warn_drop;
  assign ev_mode_wr   = mode_wr;
  assign ev_restart   = restart & ~mode_wr;
  assign ev_hold      = ~mode_converts(mode_q);
  assign ev_live_tick = period_tick & rate_ok & ~ev_hold;

  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  assign cnt_load = ev_mode_wr | ev_restart;
  assign cnt_val  = ev_mode_wr ? CW'(periods_needed(wr_mode_raw, cfg_gain, SETTLE, CAL_LONG))
                               : CW'(periods_needed(mode_q, cfg_gain, SETTLE, CAL_LONG));

  mcs_settle_cnt #(.CW(CW), .SETTLE(SETTLE)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .hold     (ev_hold),
    .step     (ev_live_tick),
    .expire   (ev_done)
  );

  // result capture
  logic noref_now, capture, clamped;
  assign noref_now = ref_det_en & ref_missing;
  assign capture   = ev_done & ~mode_is_cal(mode_q);

  mcs_result_cap #(.DW(DW)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .raw        (raw_result),
    .over       (over_range),
    .under      (under_range),
    .force_ones (noref_now),
    .data_q     (data_out),
    .clamped    (clamped)
  );

  assign ev_warn_drop = period_warn & (mode_q == M_CONT) & ~nrdy_q & ~ev_done & ~data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_CONT;
      psw_q    <= 1'b0;
      rate_q   <= RATE_RESET;
      nrdy_q   <= 1'b1;
      err_q    <= 1'b0;
      noref_q  <= 1'b0;
      chan_q   <= 3'd0;
      ofs_we_q <= 1'b0;
      fs_we_q  <= 1'b0;
    end else begin
      chan_q   <= cfg_chan;
      noref_q  <= noref_now;
      ofs_we_q <= 1'b0;
      fs_we_q  <= 1'b0;
      if (ev_mode_wr) begin
        mode_q <= wr_mode;
        psw_q  <= psw_wdata;
        rate_q <= rate_wdata;
        nrdy_q <= 1'b1;
        err_q  <= 1'b0;
      end else begin
        if (ev_restart) err_q <= 1'b0;
        if (ev_done) begin
          nrdy_q <= 1'b0;
          if (mode_is_cal(mode_q)) begin
            mode_q <= M_IDLE;
            if (mode_is_fs_cal(mode_q)) fs_we_q  <= 1'b1;
            else                        ofs_we_q <= 1'b1;
          end else begin
            err_q <= clamped;
            if (mode_q == M_SINGLE) mode_q <= M_PDOWN;
          end
        end else if (data_rd || ev_warn_drop) begin
          nrdy_q <= 1'b1;
        end
      end
    end
  end

  assign status       = {nrdy_q, err_q, noref_q, 1'b0, WIDE, chan_q};
  assign mode_now     = mode_q;
  assign rate_centihz = rate_val;
  assign psw_on       = psw_q & (mode_q != M_PDOWN);
  assign cal_ofs_we   = ofs_we_q;
  assign cal_fs_we    = fs_we_q;

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic [2:0]    mode_wdata,
  input logic [2:0]    cfg_gain,
  input logic          restart,
  input logic          data_rd,
  input logic          ref_det_en,
  input logic          ref_missing,
  input logic [7:0]    status,
  input logic [2:0]    mode_now,
  input logic          psw_on,
  input logic [DW-1:0] data_out,
  input logic          cal_ofs_we,
  input logic          cal_fs_we,
  input logic          ev_done,
  input logic          rate_ok
);
  AST_DONE_MAKES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !status[7]); // R2
  AST_SINGLE_TO_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && mode_now == 3'd1) |=> mode_now == 3'd3); // R3
  AST_CAL_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_ofs_we, cal_fs_we})); // R4
  AST_CAL_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_ofs_we || cal_fs_we) |-> mode_now == 3'd2); // R4
  AST_CAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata == 3'd5 && cfg_gain == 3'd7) |=> (mode_now == 3'd2 && !cal_fs_we)); // R5
  AST_MODE_WR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> status[7]); // R6
  AST_READ_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !ev_done) |=> status[7]); // R6
  AST_READ_LOSES_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && ev_done) |=> !status[7]); // R7
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr || restart) |=> !status[6]); // R8
  AST_NOREF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_det_en && ref_missing) |=> status[5]); // R9
  AST_BAD_RATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_ok |-> !ev_done); // R10
  AST_PDOWN_SWITCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_now == 3'd3 |-> !psw_on); // R11
  AST_IDLE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 3'd2 && !mode_wr) |=> $stable(data_out)); // R13
endmodule

bind mode_conv_seq mcs_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_wr     (mode_wr),
  .mode_wdata  (mode_wdata),
  .cfg_gain    (cfg_gain),
  .restart     (restart),
  .data_rd     (data_rd),
  .ref_det_en  (ref_det_en),
  .ref_missing (ref_missing),
  .status      (status),
  .mode_now    (mode_now),
  .psw_on      (psw_on),
  .data_out    (data_out),
  .cal_ofs_we  (cal_ofs_we),
  .cal_fs_we   (cal_fs_we),
  .ev_done     (ev_done),
  .rate_ok     (rate_ok)
);

// File: tb/mode_conv_seq_test.sv
module mode_conv_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0;
  logic [2:0]    mode_wdata = 3'd0;
  logic          psw_wdata = 1'b0;
  logic [3:0]    rate_wdata = 4'd0;
  logic          restart = 1'b0;
  logic [2:0]    cfg_gain = 3'd0;
  logic [2:0]    cfg_chan = 3'd0;
  logic          ref_det_en = 1'b0;
  logic          period_tick = 1'b0;
  logic          period_warn = 1'b0;
  logic [DW-1:0] raw_result = 24'h012345;
  logic          over_range = 1'b0;
  logic          under_range = 1'b0;
  logic          ref_missing = 1'b0;
  logic          data_rd = 1'b0;
  logic [DW-1:0] data_out;
  logic [7:0]    status;
  logic [2:0]    mode_now;
  logic [15:0]   rate_centihz;
  logic          psw_on, cal_ofs_we, cal_fs_we;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [DW-1:0] last_raw;
  logic [DW-1:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_conv_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .psw_wdata(psw_wdata), .rate_wdata(rate_wdata), .restart(restart),
    .cfg_gain(cfg_gain), .cfg_chan(cfg_chan), .ref_det_en(ref_det_en),
    .period_tick(period_tick), .period_warn(period_warn), .raw_result(raw_result),
    .over_range(over_range), .under_range(under_range), .ref_missing(ref_missing),
    .data_rd(data_rd), .data_out(data_out), .status(status), .mode_now(mode_now),
    .rate_centihz(rate_centihz), .psw_on(psw_on), .cal_ofs_we(cal_ofs_we),
    .cal_fs_we(cal_fs_we)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rate(input int code);
    case (code)
      1: return 50000;   2: return 25000;  3: return 12500;  4: return 6250;
      5: return 5000;    6: return 4160;   7: return 3330;   8: return 1960;
      9: return 1660;    10: return 1660;  11: return 1250;  12: return 1000;
      13: return 833;    14: return 625;   15: return 417;
      default: return 0;
    endcase
  endfunction

  // behavioural reference model
  int            m_mode, m_left, m_rate;
  logic          m_nrdy, m_err, m_noref, m_psw, m_ofs, m_fs;
  logic [DW-1:0] m_data;
  logic [2:0]    m_chan;

  always @(posedge clk or negedge rst_n) begin : mdl
    bit fin;
    bit clampd;
    logic [DW-1:0] word;
    if (!rst_n) begin
      m_mode = 0; m_left = 2; m_rate = 10; m_nrdy = 1; m_err = 0; m_noref = 0;
      m_psw = 0; m_ofs = 0; m_fs = 0; m_data = '0; m_chan = 0;
    end else begin
      fin = 0; m_ofs = 0; m_fs = 0;
      clampd = 1;
      if (ref_det_en && ref_missing) word = '1;
      else if (over_range) word = '1;
      else if (under_range) word = '0;
      else begin word = raw_result; clampd = 0; end
      if (mode_wr) begin
        m_mode = (mode_wdata == 3'd5 && cfg_gain == 3'd7) ? 2 : int'(mode_wdata);
        m_left = (mode_wdata == 3'd5 && cfg_gain != 3'd0) ? 4 : 2;
        m_psw = psw_wdata; m_rate = int'(rate_wdata); m_nrdy = 1; m_err = 0;
      end else begin
        if (restart) begin
          m_err = 0;
          m_left = (m_mode == 5 && cfg_gain != 3'd0) ? 4 : 2;
        end else if (m_mode == 2 || m_mode == 3) begin
          m_left = 2;
        end else if (period_tick && m_rate != 0) begin
          if (m_left == 1) fin = 1;
          else m_left = m_left - 1;
        end
        if (fin) begin
          m_nrdy = 0;
          if (m_mode >= 4) begin
            if (m_mode == 5 || m_mode == 7) m_fs = 1; else m_ofs = 1;
            m_mode = 2;
          end else begin
            m_data = word; m_err = clampd;
            if (m_mode == 1) m_mode = 3;
          end
        end else if (data_rd) m_nrdy = 1;
        else if (period_warn && m_mode == 0 && !m_nrdy) m_nrdy = 1;
      end
      m_chan = cfg_chan;
      m_noref = ref_det_en && ref_missing;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 data_out vs model", 32'(data_out), 32'(m_data));
      check("R6 status vs model", 32'(status), 32'({m_nrdy, m_err, m_noref, 1'b0, 1'b1, m_chan}));
      check("R1 mode_now vs model", 32'(mode_now), 32'(m_mode));
      check("R11 psw_on vs model", 32'(psw_on), 32'(m_psw && m_mode != 3));
      check("R4 cal_ofs_we vs model", 32'(cal_ofs_we), 32'(m_ofs));
      check("R4 cal_fs_we vs model", 32'(cal_fs_we), 32'(m_fs));
      check("R10 rate vs model", 32'(rate_centihz), 32'(exp_rate(m_rate)));
    end
  end

  task automatic edge_();
    @(posedge clk); #1;
    mode_wr = 0; restart = 0; data_rd = 0; period_tick = 0; period_warn = 0;
    raw_result = raw_result + 24'h13579B;
  endtask

  task automatic period();
    repeat (3) edge_();
    period_warn = 1; edge_();
    period_tick = 1; last_raw = raw_result; edge_();
  endtask

  task automatic wr(input int m, input bit p, input int r);
    mode_wr = 1; mode_wdata = 3'(m); psw_wdata = p; rate_wdata = 4'(r);
    edge_();
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R12 reset status", 32'(status), 32'h88);
    check("R1 reset mode", 32'(mode_now), 0);
    check("R11 reset switch", 32'(psw_on), 0);
    check("R10 reset rate", 32'(rate_centihz), 1660);

    // R2: two periods to first result after reset
    period();
    check("R2 not ready after 1st tick", 32'(status[7]), 1);
    period();
    check("R2 ready after 2nd tick", 32'(status[7]), 0);
    check("R2 first result", 32'(data_out), 32'(last_raw));

    wr(0, 1, 10);
    check("R11 switch closed", 32'(psw_on), 1);
    period(); period();
    check("R2 result after mode write", 32'(data_out), 32'(last_raw));
    // R6: warn drops pending ready
    repeat (3) edge_();
    period_warn = 1; edge_();
    check("R6 warn drops ready", 32'(status[7]), 1);
    period_tick = 1; last_raw = raw_result; edge_();
    check("R2 every period", 32'(data_out), 32'(last_raw));
    data_rd = 1; edge_();
    check("R6 read drops ready", 32'(status[7]), 1);

    // R7 collision of read and completion
    repeat (3) edge_();
    data_rd = 1; period_tick = 1; last_raw = raw_result; edge_();
    check("R7 ready after collision", 32'(status[7]), 0);
    check("R7 new data after collision", 32'(data_out), 32'(last_raw));

    // R8 clamping and clearing
    over_range = 1; period(); over_range = 0;
    check("R8 over clamps ones", 32'(data_out), 32'h00FFFFFF);
    check("R8 err set", 32'(status[6]), 1);
    restart = 1; edge_();
    check("R8 restart clears err", 32'(status[6]), 0);
    held = data_out;
    period();
    check("R2 restart delays result", 32'(data_out), 32'(held));
    period();
    check("R2 result after restart", 32'(data_out), 32'(last_raw));
    under_range = 1; period(); under_range = 0;
    check("R8 under clamps zeros", 32'(data_out), 0);
    check("R8 err set under", 32'(status[6]), 1);

    // R9 reference missing
    ref_det_en = 1; ref_missing = 1; edge_();
    check("R9 noref bit", 32'(status[5]), 1);
    period();
    check("R9 forced ones", 32'(data_out), 32'h00FFFFFF);
    check("R9 err with noref", 32'(status[6]), 1);
    ref_missing = 0; edge_();
    check("R9 noref clears", 32'(status[5]), 0);
    ref_det_en = 0;

    // R12 channel mirror
    cfg_chan = 3'd5; edge_();
    check("R12 channel bits", 32'(status[2:0]), 5);
    check("R12 width bit", 32'(status[4:3]), 1);

    // R10 invalid rate code
    held = data_out;
    wr(0, 1, 0);
    period(); period(); period();
    check("R10 code 0 ignores ticks", 32'(data_out), 32'(held));
    check("R10 code 0 not ready", 32'(status[7]), 1);
    for (int c = 1; c < 16; c++) begin
      wr(2, 0, c);
      check("R10 rate table", 32'(rate_centihz), 32'(exp_rate(c)));
    end

    // R13 idle
    held = data_out;
    period(); period(); period();
    check("R13 idle holds data", 32'(data_out), 32'(held));
    check("R1 idle mode", 32'(mode_now), 2);

    // R3 single
    wr(1, 1, 10);
    check("R1 single mode", 32'(mode_now), 1);
    period(); period();
    check("R3 single result", 32'(data_out), 32'(last_raw));
    check("R3 single to power-down", 32'(mode_now), 3);
    check("R11 power-down opens switch", 32'(psw_on), 0);
    held = data_out;
    period();
    check("R3 ready held", 32'(status[7]), 0);
    check("R13 power-down holds data", 32'(data_out), 32'(held));
    data_rd = 1; edge_();
    check("R3 read clears ready", 32'(status[7]), 1);

    // R4 calibrations
    cfg_gain = 3'd0;
    wr(4, 0, 10);
    check("R4 cal start not ready", 32'(status[7]), 1);
    period(); period();
    check("R4 zero cal offset strobe", 32'(cal_ofs_we), 1);
    check("R4 cal to idle", 32'(mode_now), 2);
    check("R4 cal ready", 32'(status[7]), 0);
    cfg_gain = 3'd3;
    wr(5, 0, 10);
    period(); period(); period();
    check("R4 long cal still running", 32'(mode_now), 5);
    period();
    check("R4 long cal fs strobe", 32'(cal_fs_we), 1);
    cfg_gain = 3'd0;
    wr(5, 0, 10);
    period(); period();
    check("R4 short fs cal strobe", 32'(cal_fs_we), 1);
    cfg_gain = 3'd7;
    wr(5, 0, 10);
    check("R5 rejected to idle", 32'(mode_now), 2);
    period(); period(); period(); period();
    check("R5 no strobe", 32'(cal_fs_we), 0);
    wr(6, 0, 10);
    period(); period();
    check("R4 system offset strobe", 32'(cal_ofs_we), 1);
    wr(7, 0, 10);
    period(); period();
    check("R4 system fs strobe", 32'(cal_fs_we), 1);

    // R11 power-down via write
    wr(3, 1, 10);
    check("R11 pd forces open", 32'(psw_on), 0);
    wr(0, 1, 10);
    check("R11 switch follows bit", 32'(psw_on), 1);
    period(); period();

    finished = 1;
    report();
    $finish;
  end
endmodule